// File: doc/BRIEF.md
# Bidirectional Byte Transceiver with Parity Generation and Checking

This block passes a data byte between two bus ports in a direction chosen by a single select input. Both ports move bytes without inversion. A single parity line changes role with the direction. When the block sends from port A to port B, it computes the parity bit from the byte on port A and drives that bit out. When it sends from port B to port A, the parity line becomes an input. The block checks it against the received byte and reports the result on an active-low error flag.

Every bidirectional pin is modelled as three separate signals: an input, an output value and a drive enable. A pad ring or an on-chip bus fabric resolves them, so the block stays synthesizable. The block is purely combinational. When the active-low enable is high, nothing is driven. A sense input chooses between even and odd parity for both generation and checking.

Top module: `xcvrParity`

## Requirements
- R1: When `oeN` is 1, every drive enable is 0: `aDrv`, `bDrv`, `parDrv` and `errDrv`. This holds whatever the other inputs are.
- R2: Any output value whose drive enable is 0 reads as 0. This applies to `aOut`, `bOut`, `parOut` and `errOut`.
- R3: Transmit is `oeN`=0 with `dirTx`=1. In transmit, `bOut` equals `aIn`, every bit of `bDrv` is 1 and every bit of `aDrv` is 0.
- R4: Receive is `oeN`=0 with `dirTx`=0. In receive, `aOut` equals `bIn`, every bit of `aDrv` is 1 and every bit of `bDrv` is 0.
- R5: In transmit with `senseOdd`=0 (even sense), `parDrv` is 1. `parOut` is 1 when `aIn` holds an odd number of ones, and 0 when it holds an even number.
- R6: In transmit with `senseOdd`=1 (odd sense), `parDrv` is 1. `parOut` is 1 when `aIn` holds an even number of ones, and 0 when it holds an odd number.
- R7: In receive, `parDrv` is 0 and `errDrv` is 1. `errOut` is 1 (no error) when the ones in `bIn` plus `parIn` add up to an even total under even sense, or to an odd total under odd sense. Otherwise `errOut` is 0.
- R8: In transmit, `errDrv` is 0 and `parIn` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oeN | input | 1 | Active-low enable for all drivers |
| dirTx | input | 1 | 1 = port A to port B (transmit), 0 = port B to port A (receive) |
| senseOdd | input | 1 | 0 = even parity, 1 = odd parity |
| aIn | input | DATA_W | Value seen on port A pins |
| aOut | output | DATA_W | Value driven onto port A |
| aDrv | output | DATA_W | Per-pin drive enable for port A |
| bIn | input | DATA_W | Value seen on port B pins |
| bOut | output | DATA_W | Value driven onto port B |
| bDrv | output | DATA_W | Per-pin drive enable for port B |
| parIn | input | 1 | Value seen on the parity pin |
| parOut | output | 1 | Generated parity bit |
| parDrv | output | 1 | Drive enable for the parity pin |
| errOut | output | 1 | Check result, 0 = parity error |
| errDrv | output | 1 | Drive enable for the error flag |

## Verification
The bench builds the block with the default `DATA_W` of 8. At that width an exhaustive sweep is practical: every byte value, combined with both directions, both parity senses, both parity-line levels and both enable levels. Every ones-count from zero to eight therefore reaches both the generator and the checker. The sweep also shows that `parIn` has no effect while transmitting, and that the disabled state holds for every combination of the other inputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes from the direction control to the datapath
  typedef struct packed {
    logic aDrive;    // port A is driven (receive)
    logic bDrive;    // port B is driven (transmit)
    logic parDrive;  // parity pin is driven (transmit)
    logic errDrive;  // error flag is driven (receive)
    logic useA;      // parity tree watches port A input
  } xcvrStrobes_t;
endpackage

// File: rtl/xcvrCtl.sv
module xcvrCtl
  import xcvr_pkg::*;
(
  input  logic         oeN,
  input  logic         dirTx,
  output xcvrStrobes_t stb
);
  logic enabled;
  assign enabled = ~oeN;

  always_comb begin
    stb.aDrive   = enabled & ~dirTx;
    stb.bDrive   = enabled &  dirTx;
    stb.parDrive = enabled &  dirTx;
    stb.errDrive = enabled & ~dirTx;
    stb.useA     = dirTx;
  end
endmodule

// File: rtl/parityTree.sv
module parityTree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic             oddOnes
);
  logic [WIDTH:0] acc;
  assign acc[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign acc[i+1] = acc[i] ^ vec[i];
  end

  assign oddOnes = acc[WIDTH];
endmodule

// File: rtl/xcvrDatapath.sv
module xcvrDatapath
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  xcvrStrobes_t      stb,
  input  logic              senseOdd,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              parIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] aDrv,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] bDrv,
  output logic              parOut,
  output logic              parDrv,
  output logic              errOut,
  output logic              errDrv
);
  logic [DATA_W-1:0] treeIn;
  logic              treeOdd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign aOut[i] = stb.aDrive & bIn[i];
    assign bOut[i] = stb.bDrive & aIn[i];
    assign aDrv[i] = stb.aDrive;
    assign bDrv[i] = stb.bDrive;
  end

  // One shared tree: port A input when sending, received byte otherwise
  assign treeIn = stb.useA ? aIn : aOut;

  parityTree #(.WIDTH(DATA_W)) uTree (
    .vec     (treeIn),
    .oddOnes (treeOdd)
  );

  assign parDrv = stb.parDrive;
  assign parOut = stb.parDrive & (treeOdd ^ senseOdd);
  assign errDrv = stb.errDrive;
  assign errOut = stb.errDrive & ~(treeOdd ^ parIn ^ senseOdd);
endmodule

// File: rtl/xcvrParity.sv
module xcvrParity
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              oeN,
  input  logic              dirTx,
  input  logic              senseOdd,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] aDrv,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] bDrv,
  input  logic              parIn,
  output logic              parOut,
  output logic              parDrv,
  output logic              errOut,
  output logic              errDrv
);
  xcvrStrobes_t stb;

  xcvrCtl uCtl (
    .oeN   (oeN),
    .dirTx (dirTx),
    .stb   (stb)
  );

  xcvrDatapath #(.DATA_W(DATA_W)) uPath (
    .stb      (stb),
    .senseOdd (senseOdd),
    .aIn      (aIn),
    .bIn      (bIn),
    .parIn    (parIn),
    .aOut     (aOut),
    .aDrv     (aDrv),
    .bOut     (bOut),
    .bDrv     (bDrv),
    .parOut   (parOut),
    .parDrv   (parDrv),
    .errOut   (errOut),
    .errDrv   (errDrv)
  );
endmodule

// File: rtl/xcvrParityChk.sv
module xcvrParityChk #(
  parameter int DATA_W = 8
) (
  input logic              oeN,
  input logic              dirTx,
  input logic              senseOdd,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] aOut,
  input logic [DATA_W-1:0] aDrv,
  input logic [DATA_W-1:0] bIn,
  input logic [DATA_W-1:0] bOut,
  input logic [DATA_W-1:0] bDrv,
  input logic              parIn,
  input logic              parOut,
  input logic              parDrv,
  input logic              errOut,
  input logic              errDrv
);
  always_comb begin
    if (oeN) begin
      // R1
      all_quiet_chk: assert (aDrv == '0 && bDrv == '0 && !parDrv && !errDrv);
    end
    // R2
    undriven_zero_chk: assert (((aOut & ~aDrv) == '0) && ((bOut & ~bDrv) == '0)
                               && (parDrv || !parOut) && (errDrv || !errOut));
    if (!oeN && dirTx) begin
      // R3
      tx_pass_chk: assert (bOut == aIn && bDrv == '1 && aDrv == '0);
      // R5
      tx_even_chk: assert (senseOdd || (parDrv && ((($countones(aIn) + int'(parOut)) % 2) == 0)));
      // R6
      tx_odd_chk: assert (!senseOdd || (parDrv && ((($countones(aIn) + int'(parOut)) % 2) == 1)));
      // R8
      tx_noerr_chk: assert (!errDrv);
    end
    if (!oeN && !dirTx) begin
      // R4
      rx_pass_chk: assert (aOut == bIn && aDrv == '1 && bDrv == '0);
      // R7
      rx_check_chk: assert (!parDrv && errDrv &&
        (errOut == ((($countones(bIn) + int'(parIn)) % 2) == int'(senseOdd))));
    end
  end
endmodule

bind xcvrParity xcvrParityChk #(.DATA_W(DATA_W)) uChk (
  .oeN(oeN), .dirTx(dirTx), .senseOdd(senseOdd),
  .aIn(aIn), .aOut(aOut), .aDrv(aDrv),
  .bIn(bIn), .bOut(bOut), .bDrv(bDrv),
  .parIn(parIn), .parOut(parOut), .parDrv(parDrv),
  .errOut(errOut), .errDrv(errDrv)
);

// File: tb/tb_xcvrParity.sv
module tb_xcvrParity;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] aOut, aDrv, bOut, bDrv;
    logic parOut, parDrv, errOut, errDrv;
    logic oeN, dirTx, senseOdd;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         oeN = 1'b1, dirTx = 1'b0, senseOdd = 1'b0, parIn = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, aDrv, bOut, bDrv;
  logic         parOut, parDrv, errOut, errDrv;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  expItem_t sb[$];

  xcvrParity #(.DATA_W(W)) dut (
    .oeN(oeN), .dirTx(dirTx), .senseOdd(senseOdd),
    .aIn(aIn), .aOut(aOut), .aDrv(aDrv),
    .bIn(bIn), .bOut(bOut), .bDrv(bDrv),
    .parIn(parIn), .parOut(parOut), .parDrv(parDrv),
    .errOut(errOut), .errDrv(errDrv)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: apply one vector and push its expected outputs
  task automatic drive(logic o, logic d, logic s, logic p, logic [W-1:0] av, logic [W-1:0] bv);
    expItem_t e;
    @(posedge clk);
    oeN <= o; dirTx <= d; senseOdd <= s; parIn <= p; aIn <= av; bIn <= bv;
    e.oeN = o; e.dirTx = d; e.senseOdd = s;
    e.aOut = '0; e.aDrv = '0; e.bOut = '0; e.bDrv = '0;
    e.parOut = 0; e.parDrv = 0; e.errOut = 0; e.errDrv = 0;
    if (!o && d) begin
      e.bOut = av; e.bDrv = '1;
      e.parDrv = 1;
      e.parOut = (($countones(av) % 2) == 1) ? !s : s;
    end else if (!o && !d) begin
      e.aOut = bv; e.aDrv = '1;
      e.errDrv = 1;
      e.errOut = ((($countones(bv) + int'(p)) % 2) == int'(s));
    end
    sb.push_back(e);
  endtask

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      expItem_t e;
      e = sb.pop_front();
      if (e.oeN) begin
        chk("R1 drive enables", {aDrv, bDrv, parDrv, errDrv}, 0);
        chk("R2 undriven values", {aOut, bOut, parOut, errOut}, 0);
      end else if (e.dirTx) begin
        chk("R3 port B value", bOut, e.bOut);
        chk("R3 drive enables", {aDrv, bDrv}, {e.aDrv, e.bDrv});
        chk("R2 port A idle", aOut, 0);
        if (e.senseOdd) chk("R6 odd parity out", {parDrv, parOut}, {e.parDrv, e.parOut});
        else            chk("R5 even parity out", {parDrv, parOut}, {e.parDrv, e.parOut});
        chk("R8 error flag undriven", {errDrv, errOut}, 0);
      end else begin
        chk("R4 port A value", aOut, e.aOut);
        chk("R4 drive enables", {aDrv, bDrv}, {e.aDrv, e.bDrv});
        chk("R2 port B idle", {bOut, parOut}, 0);
        chk("R7 check result", {parDrv, errDrv, errOut}, {e.parDrv, e.errDrv, e.errOut});
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state before any stimulus
    @(negedge clk);
    chk("R1 idle drive enables", {aDrv, bDrv, parDrv, errDrv}, 0);
    chk("R2 idle values", {aOut, bOut, parOut, errOut}, 0);
    for (int o = 0; o < 2; o++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 2; p++)
            for (int v = 0; v < 256; v++)
              drive(o[0], d[0], s[0], p[0], v[W-1:0], W'(v ^ 8'h5a));
    // R8: same byte in transmit with parity line flipped gives same outputs
    drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h07, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h07, 8'h00);
    repeat (3) @(posedge clk);
    chk("R8 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule